// File: doc/BRIEF.md
# NCO Divider with Scheduled Period Adjustment

This block divides a fast input clock down to a sample strobe for a digital phase-locked loop. In steady state it emits a one-cycle pulse every N input clocks, where N is a programmable default divide number. To pull the loop's phase, software can schedule a brief correction. After a programmed number of samples, the divide number is raised or lowered by one count on frame-start samples only. This repeats a programmed number of times, and the divider then returns to the default.

Three registers are written through a small write port and can be read back through a combinational read port:

| Address | Contents | Reset value |
|---|---|---|
| 0 | Default divide, bits [6:0] | 0x40 |
| 1 | Adjustment delay, 8 bits | 0x00 |
| 2 | Delta in bits [7:4], repeat count in bits [3:0] | 0x00 |

Writing the delay register arms a new adjustment, so it is written last. Two strobes from the surrounding serial logic steer the schedule:

- A secondary-transfer strobe starts the delay countdown.
- A frame-start strobe marks the samples that may be stretched or shortened.

The scheduler is a four-state machine:

- **IDLE**: no adjustment pending.
- **ARMED**: waiting for a transfer strobe.
- **DELAY**: counting down samples.
- **ADJUST**: applying the delta on frame-start samples.

Its transitions are:

- **arm**: any state to ARMED, on a delay-register write. This takes priority over every other transition.
- **start_count**: ARMED to DELAY, on a transfer strobe with a nonzero delay.
- **start_now**: ARMED to ADJUST, on a transfer strobe with zero delay.
- **delay_done**: DELAY to ADJUST, on the sample tick that takes the countdown from 1.
- **nothing_to_do**: ADJUST to IDLE, when the repeat count or the delta is zero.
- **last_repeat**: ADJUST to IDLE, on the adjusted tick that uses up the repeat count.

Top module: `nco_adj_divider`

## Requirements
- R1: A synchronous reset sets the default divide to 64 and the delay and delta/repeat registers to 0. It leaves the scheduler in IDLE with `adj_busy` low and restarts the count, so the first `sample_tick` appears in the 64th cycle after reset is released.
- R2: Reads are combinational.
  - Address 0 returns the 7-bit default divide with bit 7 zero.
  - Address 1 returns the delay register.
  - Address 2 returns the delta/repeat register.
  - Address 3 returns zero, and writes to address 3 are ignored.
- R3: `sample_tick` is high for exactly one cycle per period. The period length is loaded on each tick and applies to the next period. Outside an adjustment, that length is the default divide value as it stands in the tick cycle.
- R4: Any period length below 2 is raised to 2, so a default divide of 0 or 1 gives a tick every second clock.
- R5: A write to address 1 moves the scheduler to ARMED in the next cycle, with `adj_busy` high. It snapshots the delta and repeat fields and cancels any adjustment in progress.
- R6: In ARMED, a transfer strobe with a nonzero delay D enters DELAY. Each later tick decrements the countdown, and the tick that sees countdown 1 enters ADJUST. Transfer strobes are ignored in IDLE, DELAY and ADJUST.
- R7: In ARMED, a transfer strobe with delay 0 enters ADJUST directly.
- R8: In ADJUST, a tick with `frame_start` high loads default+delta as the next period length and decrements the repeat count. The tick that uses the last repeat returns the scheduler to IDLE. Ticks without `frame_start` load the default.
- R9: The 4-bit delta field is two's complement and is clamped to one step. Code 0 means no change, codes 1..7 mean +1, and codes 8..15 mean -1.
- R10: If the snapshot repeat count is 0 or the delta is 0, ADJUST returns to IDLE in the next cycle and no period differs from the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| frame_start | input | 1 | High during a tick that begins a data frame |
| xfer_strobe | input | 1 | Secondary-transfer strobe; starts the delay countdown |
| sample_tick | output | 1 | One-cycle divided sample strobe |
| adj_busy | output | 1 | High while an adjustment is armed, counting or applying |

## Verification
The assertions assume that `rst` is asserted in the first cycle, and that the write and read addresses are always known two-bit values. They do not assume any timing for the strobes. `frame_start` and `xfer_strobe` may arrive in any cycle, including the same cycle as a tick or a register write. The stimulus keeps to these assumptions and deliberately hits the overlaps:

- writes that coincide with ticks and with transfer strobes;
- a transfer strobe sent while the scheduler is idle;
- default divides of 0 and 1;
- delta codes across the full 4-bit range.

Most random default divide values stay small, so that many periods fit into the run.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int DW     = 8;           // register width
    localparam int AW     = 2;           // register address width
    localparam int DIV_W  = 7;           // default divide field
    localparam int DLY_W  = 8;           // delay register
    localparam int DLT_W  = 4;           // delta field
    localparam int RPT_W  = 4;           // repeat field
    localparam int PW     = DIV_W + 1;   // period width, holds default+1
    localparam int MIN_DIV = 2;

    localparam logic [AW-1:0]    A_DIV   = 2'd0;
    localparam logic [AW-1:0]    A_DLY   = 2'd1;
    localparam logic [AW-1:0]    A_DLT   = 2'd2;
    localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(64);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DELAY,
        ST_ADJUST
    } adj_state_e;

    typedef struct packed {
        logic inc;
        logic dec;
    } step_t;

    // Clamp a two's-complement delta to a single step.
    function automatic step_t clamp_step(logic [DLT_W-1:0] raw);
        step_t s;
        s.inc = (raw != '0) && !raw[DLT_W-1];
        s.dec = raw[DLT_W-1];
        return s;
    endfunction
endpackage

// File: rtl/nco_regs.sv
module nco_regs
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [DIV_W-1:0] def_div,
    output logic [DLY_W-1:0] dly_val,
    output logic [DLT_W-1:0] dlt_raw,
    output logic [RPT_W-1:0] rpt_val,
    output logic             arm
);
    logic [DIV_W-1:0]       div_q;
    logic [DLY_W-1:0]       dly_q;
    logic [DLT_W+RPT_W-1:0] adj_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_RST;
            dly_q <= '0;
            adj_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_DIV) div_q <= wr_data[DIV_W-1:0];
            if (wr_addr == A_DLY) dly_q <= wr_data[DLY_W-1:0];
            if (wr_addr == A_DLT) adj_q <= wr_data[DLT_W+RPT_W-1:0];
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_DIV:   rd_data = DW'(div_q);
            A_DLY:   rd_data = DW'(dly_q);
            A_DLT:   rd_data = DW'(adj_q);
            default: rd_data = '0;
        endcase
    end

    assign arm     = wr_en && (wr_addr == A_DLY);
    assign def_div = div_q;
    assign dly_val = dly_q;
    assign dlt_raw = adj_q[DLT_W+RPT_W-1:RPT_W];
    assign rpt_val = adj_q[RPT_W-1:0];
endmodule

// File: rtl/nco_sched.sv
module nco_sched
    import nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             xfer_strobe,
    input  logic             frame_start,
    input  logic             tick,
    input  logic [DIV_W-1:0] def_div,
    input  logic [DLY_W-1:0] dly_val,
    input  logic [DLT_W-1:0] dlt_raw,
    input  logic [RPT_W-1:0] rpt_val,
    output logic             busy,
    output logic [PW-1:0]    next_div
);
    adj_state_e       state_q, state_d;
    logic [DLY_W-1:0] dcnt_q;
    logic [RPT_W-1:0] rcnt_q;
    step_t            step_q;
    logic             has_step;
    logic             apply;

    assign has_step = step_q.inc || step_q.dec;
    assign apply    = (state_q == ST_ADJUST) && (rcnt_q != '0) && has_step
                      && tick && frame_start;

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED:
                if (xfer_strobe)
                    state_d = (dly_val == '0) ? ST_ADJUST : ST_DELAY;
            ST_DELAY:
                if (tick && dcnt_q == DLY_W'(1)) state_d = ST_ADJUST;
            ST_ADJUST:
                if (rcnt_q == '0 || !has_step)              state_d = ST_IDLE;
                else if (apply && rcnt_q == RPT_W'(1))      state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (arm) state_d = ST_ARMED;
    end

    // State register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
            rcnt_q  <= '0;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                rcnt_q <= rpt_val;
                step_q <= clamp_step(dlt_raw);
            end else if (state_q == ST_ARMED && xfer_strobe) begin
                dcnt_q <= dly_val;
            end else if (state_q == ST_DELAY && tick) begin
                dcnt_q <= dcnt_q - DLY_W'(1);
            end else if (apply) begin
                rcnt_q <= rcnt_q - RPT_W'(1);
            end
        end
    end

    // Outputs
    logic [PW-1:0] base, sum;
    always_comb begin
        busy = (state_q != ST_IDLE);
        base = PW'(def_div);
        sum  = base;
        if (apply && step_q.inc)      sum = base + PW'(1);
        else if (apply && step_q.dec) sum = (base == '0) ? '0 : base - PW'(1);
        next_div = (sum < PW'(MIN_DIV)) ? PW'(MIN_DIV) : sum;
    end
endmodule

// File: rtl/nco_count.sv
module nco_count
    import nco_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] next_div,
    output logic          tick
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] per_q;

    assign tick = (cnt_q == per_q - PW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            per_q <= PW'(DIV_RST);
        end else if (tick) begin
            cnt_q <= '0;
            per_q <= next_div;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end
endmodule

// File: rtl/nco_adj_divider.sv
module nco_adj_divider
    import nco_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          frame_start,
    input  logic          xfer_strobe,
    output logic          sample_tick,
    output logic          adj_busy
);
    logic [DIV_W-1:0] def_div;
    logic [DLY_W-1:0] dly_val;
    logic [DLT_W-1:0] dlt_raw;
    logic [RPT_W-1:0] rpt_val;
    logic             arm;
    logic [PW-1:0]    next_div;

    nco_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .def_div(def_div), .dly_val(dly_val), .dlt_raw(dlt_raw),
        .rpt_val(rpt_val), .arm(arm)
    );

    nco_sched u_sched (
        .clk(clk), .rst(rst), .arm(arm), .xfer_strobe(xfer_strobe),
        .frame_start(frame_start), .tick(sample_tick), .def_div(def_div),
        .dly_val(dly_val), .dlt_raw(dlt_raw), .rpt_val(rpt_val),
        .busy(adj_busy), .next_div(next_div)
    );

    nco_count u_count (
        .clk(clk), .rst(rst), .next_div(next_div), .tick(sample_tick)
    );
endmodule

// File: rtl/nco_adj_divider_chk.sv
module nco_adj_divider_chk
    import nco_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic          sample_tick,
    input logic          adj_busy
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !adj_busy); // R1
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst) sample_tick |=> !sample_tick); // R4
    AST_ARM_BUSY: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_addr == A_DLY) |=> adj_busy); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!adj_busy && !(wr_en && wr_addr == A_DLY)) |=> !adj_busy); // R6
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_addr == 2'd3) |-> (rd_data == '0)); // R2
    AST_DIV_TOPBIT: assert property (@(posedge clk) disable iff (rst) (rd_addr == A_DIV) |-> !rd_data[DW-1]); // R2
endmodule

bind nco_adj_divider nco_adj_divider_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_data(rd_data), .sample_tick(sample_tick),
    .adj_busy(adj_busy)
);

// File: tb/tb_nco_adj_divider.sv
module tb_nco_adj_divider;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       frame_start = 1'b0;
    logic       xfer_strobe = 1'b0;
    logic       sample_tick;
    logic       adj_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    nco_adj_divider dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_start(frame_start), .xfer_strobe(xfer_strobe),
        .sample_tick(sample_tick), .adj_busy(adj_busy)
    );

    // Reference model state (states: 0 idle, 1 armed, 2 delay, 3 adjust)
    int m_def, m_dly, m_adj, m_cnt, m_per, m_st, m_dcnt, m_rcnt, m_step;

    // R9: codes 1..7 -> +1, 8..15 -> -1, 0 -> 0
    function automatic int clamp_delta(int raw);
        if (raw == 0) return 0;
        return (raw >= 8) ? -1 : 1;
    endfunction

    // R4: lengths below 2 become 2
    function automatic int period_of(int base, int step);
        int v = base + step;
        return (v < 2) ? 2 : v;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return m_def;
            1: return m_dly;
            2: return m_adj;
            default: return 0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit t, ap, arm;
        int ns, nd, nr, nstep;
        if (rst) begin
            m_def = 64; m_dly = 0; m_adj = 0; m_cnt = 0; m_per = 64;
            m_st = 0; m_dcnt = 0; m_rcnt = 0; m_step = 0;
            return;
        end
        t   = (m_cnt == m_per - 1);
        ap  = (m_st == 3) && (m_rcnt != 0) && (m_step != 0) && t && frame_start;
        arm = wr_en && (wr_addr == 2'd1);
        ns = m_st; nd = m_dcnt; nr = m_rcnt; nstep = m_step;
        if (arm) begin                       // R5
            ns = 1; nr = m_adj & 15; nstep = clamp_delta(m_adj >> 4);
        end else begin
            case (m_st)
                1: if (xfer_strobe) begin     // R6 R7
                    nd = m_dly; ns = (m_dly == 0) ? 3 : 2;
                end
                2: if (t) begin
                    nd = m_dcnt - 1; if (m_dcnt == 1) ns = 3;
                end
                3: if (m_rcnt == 0 || m_step == 0) ns = 0;      // R10
                   else if (ap) begin nr = m_rcnt - 1; if (m_rcnt == 1) ns = 0; end // R8
                default: ;
            endcase
        end
        if (t) begin m_cnt = 0; m_per = period_of(m_def, ap ? m_step : 0); end   // R3
        else m_cnt++;
        m_st = ns; m_dcnt = nd; m_rcnt = nr; m_step = nstep;
        if (wr_en) begin
            case (wr_addr)
                2'd0: m_def = wr_data & 127;
                2'd1: m_dly = wr_data;
                2'd2: m_adj = wr_data;
                default: ;                     // R2 address 3 ignored
            endcase
        end
    endtask

    task automatic cyc(bit r, bit we, int wa, int wd, bit fs, bit xs);
        rst = r; wr_en = we; wr_addr = 2'(wa); wr_data = 8'(wd);
        frame_start = fs; xfer_strobe = xs; rd_addr = 2'($urandom % 4);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(sample_tick == (m_cnt == m_per - 1), "R3 R4 R8 R9 R10 sample_tick",
              int'(sample_tick), int'(m_cnt == m_per - 1));
        check(adj_busy == (m_st != 0), "R5 R6 R7 R8 R10 adj_busy",
              int'(adj_busy), int'(m_st != 0));
        check(int'(rd_data) == exp_rd(int'(rd_addr)), "R2 rd_data",
              int'(rd_data), exp_rd(int'(rd_addr)));
    endtask

    task automatic idle(int n, bit fs);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, fs, 0);
    endtask

    task automatic wr(int a, int d);
        cyc(0, 1, a, d, 0, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        // R1: reset values seen at the ports
        rst = 0; rd_addr = 2'd0; #1;
        check(rd_data == 8'h40 && !adj_busy, "R1 reset state", int'(rd_data), 'h40);
        idle(70, 0);                                  // R1 first tick at 64
        // R3: short default, then +1 adjustment with delay 2 (R6, R8, R9)
        wr(0, 4); idle(10, 0);
        wr(2, 8'h13); wr(1, 2);
        idle(5, 1);                                   // R6 still armed without strobe
        cyc(0, 0, 0, 0, 1, 1);
        idle(40, 1);
        // R7 R9: delay 0, delta code F -> -1
        wr(2, 8'hF2); wr(1, 0); cyc(0, 0, 0, 0, 0, 1); idle(30, 1);
        // R10: repeat 0 and delta 0
        wr(2, 8'h50); wr(1, 1); cyc(0, 0, 0, 0, 0, 1); idle(20, 1);
        wr(2, 8'h04); wr(1, 0); cyc(0, 0, 0, 0, 0, 1); idle(20, 1);
        // R5: rearm cancels adjustment in progress
        wr(2, 8'h7F); wr(1, 3); cyc(0, 0, 0, 0, 0, 1); idle(9, 1);
        wr(1, 1); idle(4, 1); cyc(0, 0, 0, 0, 1, 1); idle(40, 1);
        // R4: default 0 and 1 with -1
        wr(0, 0); idle(10, 0); wr(0, 1); wr(2, 8'h83); wr(1, 0);
        cyc(0, 0, 0, 0, 1, 1); idle(20, 1);
        // R6: transfer strobe while idle is ignored; R2 address 3 write ignored
        wr(3, 8'hAA); cyc(0, 0, 0, 0, 0, 1); idle(10, 0);
        // Random phase
        for (int i = 0; i < 20000; i++) begin
            int k = $urandom % 1000;
            bit fs = ($urandom % 10) < 3;
            bit xs = ($urandom % 20) == 0;
            if (k == 0) cyc(1, 0, 0, 0, fs, xs);
            else if (k < 30) begin
                int a = $urandom % 4;
                int d = $urandom % 256;
                if (a == 0) d = ($urandom % 8 == 0) ? d : $urandom % 12;
                if (a == 1) d = $urandom % 7;
                cyc(0, 1, a, d, fs, xs);
            end else cyc(0, 0, 0, 0, fs, xs);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule